// File: doc/BRIEF.md
# Virtually Addressed Data Cache with Process Tags

This block is a direct-mapped, write-back, write-allocate data cache that is looked up with the virtual address only. The line index and the stored tag both come from the virtual address. The requesting process identifier is stored beside the tag and must match as well. Address translation runs in the same cycle as the lookup: the block presents the request to a translation port and reads back a physical address and a fault flag combinationally.

On a hit the translated address is not used. On a miss it becomes the fill address, and it is also stored in the line. When that line is later evicted dirty, the write-back goes to the stored physical line address, so no second translation is needed. Aliased virtual addresses must agree in their index bits; the block does not detect synonyms.

A single-cycle flush input drops every line when process identifiers are reused. Lines are moved to and from memory as one full-width beat with a request/acknowledge handshake.

Top module: `virt_pid_cache`

## Requirements
- R1: After reset, `req_ready` is 1 while `flush` is 0, `resp_valid` and `mem_req` are 0, and every line is invalid, so the first access to any address misses.
- R2: With OFF = log2(LINE_BYTES) and IDX = log2(LINES), the line index is `req_vaddr[OFF+IDX-1:OFF]`, the virtual tag is `req_vaddr[VA_W-1:OFF+IDX]`, and the 32-bit word inside the line is `req_vaddr[OFF-1:2]`. Word w sits at bits [32w+31:32w] of a line. `req_vaddr[1:0]` is ignored.
- R3: A hit is decided by a valid line whose stored virtual tag and process identifier both equal the request's. The translated physical address has no effect on a hit. The response comes in the cycle after acceptance, with no memory request.
- R4: The same virtual address issued under a different process identifier misses, and the line is filled from that process's translated address.
- R5: When `xlt_fault` is 1 for an accepted request, `resp_valid` and `resp_fault` are 1 in the next cycle. No memory request is made, and no line is written, evicted or marked dirty.
- R6: A miss whose victim is invalid or clean issues one memory read (`mem_we`=0). The read goes to the translated address with its low OFF bits cleared. The response after `mem_ack` carries the requested word of the returned line.
- R7: A write hit replaces only the addressed word in the line and marks the line dirty, without a memory request.
- R8: A miss whose victim is valid and dirty first writes the whole victim line (`mem_we`=1) to the physical line address stored with that line. It then reads the new line.
- R9: A write miss fills the line, merges the write word into it, and leaves the line dirty.
- R10: A cycle with `flush`=1 clears every valid bit and holds `req_ready` at 0. Dirty lines are dropped without write-back.
- R11: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we` and `mem_addr` keep their values into the next cycle.
- R12: `req_ready` is 0 while a miss is being serviced. Each accepted request produces exactly one `resp_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_pid | input | PID_W | Process identifier of the request |
| req_vaddr | input | VA_W | Virtual byte address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Response pulse |
| resp_fault | output | 1 | Access aborted by translation fault |
| resp_rdata | output | 32 | Load data |
| xlt_valid | output | 1 | Translation lookup in progress |
| xlt_pid | output | PID_W | Process identifier to translate |
| xlt_vaddr | output | VA_W | Virtual address to translate |
| xlt_paddr | input | PA_W | Translated physical address, same cycle |
| xlt_fault | input | 1 | Translation or permission fault, same cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = line fill |
| mem_addr | output | PA_W | Line-aligned physical byte address |
| mem_wline | output | LINE_BYTES*8 | Write-back line data |
| mem_ack | input | 1 | Transfer complete, fill data valid |
| mem_rline | input | LINE_BYTES*8 | Fill line data |

## Verification
The bench builds the cache with 4 lines of 8 bytes: a 2-bit index, a 1-bit word select and 32-bit addresses. With only four sets, virtual addresses 32 bytes apart collide in the same set. Dirty evictions, refills after write-back and cross-process conflicts therefore take only a few accesses. A write hit touches only one word of a two-word line, so it is visible. Because the bench's translation offset can be changed at run time, a hit that still returns the old data shows that the physical address plays no part in the lookup.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } vpc_state_e;
endpackage

// File: rtl/vpc_tag_store.sv
module vpc_tag_store #(
  parameter int LINES  = 256,
  parameter int IDX_W  = 8,
  parameter int VTAG_W = 19,
  parameter int PID_W  = 8,
  parameter int PLN_W  = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [IDX_W-1:0]  idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [VTAG_W-1:0] rd_vtag,
  output logic [PID_W-1:0]  rd_pid,
  output logic [PLN_W-1:0]  rd_pline,
  input  logic              fill,
  input  logic              fill_dirty,
  input  logic [VTAG_W-1:0] new_vtag,
  input  logic [PID_W-1:0]  new_pid,
  input  logic [PLN_W-1:0]  new_pline,
  input  logic              mark_dirty
);
  logic [LINES-1:0]  vld;
  logic [LINES-1:0]  drt;
  logic [VTAG_W-1:0] vtag_a  [LINES];
  logic [PID_W-1:0]  pid_a   [LINES];
  logic [PLN_W-1:0]  pline_a [LINES];

  assign rd_valid = vld[idx];
  assign rd_dirty = drt[idx];
  assign rd_vtag  = vtag_a[idx];
  assign rd_pid   = pid_a[idx];
  assign rd_pline = pline_a[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      drt <= '0;
    end else if (flush) begin
      vld <= '0;
    end else begin
      if (fill) begin
        vld[idx] <= 1'b1;
        drt[idx] <= fill_dirty;
      end
      if (mark_dirty) drt[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      vtag_a[idx]  <= new_vtag;
      pid_a[idx]   <= new_pid;
      pline_a[idx] <= new_pline;
    end
  end

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));
  // R1
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> (vld == '0));
endmodule

// File: rtl/vpc_data_store.sv
module vpc_data_store #(
  parameter int LINES  = 256,
  parameter int IDX_W  = 8,
  parameter int LINE_W = 256
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              we,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] arr [LINES];

  assign rd_line = arr[idx];

  always_ff @(posedge clk) begin
    if (we) arr[idx] <= wr_line;
  end
endmodule

// File: rtl/vpc_ctrl.sv
module vpc_ctrl
  import vpc_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PID_W      = 8,
  parameter int LINES      = 256,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(LINES),
  localparam int VTAG_W = VA_W - IDX_W - OFF_W,
  localparam int PLN_W  = PA_W - OFF_W,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WSEL_W = OFF_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [31:0]       resp_rdata,
  input  logic [PA_W-1:0]   xlt_paddr,
  input  logic              xlt_fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rline,
  output logic [IDX_W-1:0]  ts_idx,
  input  logic              ts_valid,
  input  logic              ts_dirty,
  input  logic [VTAG_W-1:0] ts_vtag,
  input  logic [PID_W-1:0]  ts_pid,
  input  logic [PLN_W-1:0]  ts_pline,
  output logic              ts_fill,
  output logic              ts_fill_dirty,
  output logic [VTAG_W-1:0] ts_new_vtag,
  output logic [PID_W-1:0]  ts_new_pid,
  output logic [PLN_W-1:0]  ts_new_pline,
  output logic              ts_mark_dirty,
  input  logic [LINE_W-1:0] ds_line,
  output logic              ds_we,
  output logic [LINE_W-1:0] ds_wline
);
  localparam logic [PA_W-1:0] LINE_MASK = ~(PA_W'(LINE_BYTES - 1));

  function automatic logic [IDX_W-1:0] idx_of(input logic [VA_W-1:0] va);
    return va[OFF_W +: IDX_W];
  endfunction
  function automatic logic [VTAG_W-1:0] vtag_of(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: VTAG_W];
  endfunction
  function automatic logic [WSEL_W-1:0] wsel_of(input logic [VA_W-1:0] va);
    return va[2 +: WSEL_W];
  endfunction
  function automatic logic [31:0] get_word(input logic [LINE_W-1:0] ln,
                                           input logic [WSEL_W-1:0] w);
    return ln[32*w +: 32];
  endfunction
  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] ln,
                                                 input logic [WSEL_W-1:0] w,
                                                 input logic [31:0] d);
    logic [LINE_W-1:0] r;
    r = ln;
    r[32*w +: 32] = d;
    return r;
  endfunction

  vpc_state_e state, st_nxt;

  logic [IDX_W-1:0]  l_idx;
  logic [VTAG_W-1:0] l_vtag;
  logic [PID_W-1:0]  l_pid;
  logic [PA_W-1:0]   l_paddr;
  logic [PLN_W-1:0]  l_vict_pline;
  logic [WSEL_W-1:0] l_wsel;
  logic              l_write;
  logic [31:0]       l_wdata;

  logic accept, lookup_hit, acc_fault, acc_hit, acc_miss, victim_dirty, fill_done;

  assign req_ready    = (state == ST_IDLE) && !flush;
  assign accept       = req_valid && req_ready;
  assign ts_idx       = (state == ST_IDLE) ? idx_of(req_vaddr) : l_idx;
  assign lookup_hit   = ts_valid && (ts_vtag == vtag_of(req_vaddr)) && (ts_pid == req_pid);
  assign acc_fault    = accept && xlt_fault;
  assign acc_hit      = accept && !xlt_fault && lookup_hit;
  assign acc_miss     = accept && !xlt_fault && !lookup_hit;
  assign victim_dirty = ts_valid && ts_dirty;
  assign fill_done    = (state == ST_FILL) && mem_ack;

  always_comb begin
    st_nxt = state;
    case (state)
      ST_IDLE:  if (acc_miss) st_nxt = victim_dirty ? ST_WBACK : ST_FILL;
      ST_WBACK: if (mem_ack) st_nxt = ST_FILL;
      ST_FILL:  if (mem_ack) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= st_nxt;
  end

  always_ff @(posedge clk) begin
    if (acc_miss) begin
      l_idx        <= idx_of(req_vaddr);
      l_vtag       <= vtag_of(req_vaddr);
      l_pid        <= req_pid;
      l_paddr      <= xlt_paddr;
      l_vict_pline <= ts_pline;
      l_wsel       <= wsel_of(req_vaddr);
      l_write      <= req_write;
      l_wdata      <= req_wdata;
    end
  end

  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = (state == ST_WBACK) ? {l_vict_pline, OFF_W'(0)} : (l_paddr & LINE_MASK);
  assign mem_wline = ds_line;

  assign ts_fill       = fill_done;
  assign ts_fill_dirty = l_write;
  assign ts_new_vtag   = l_vtag;
  assign ts_new_pid    = l_pid;
  assign ts_new_pline  = l_paddr[PA_W-1 -: PLN_W];
  assign ts_mark_dirty = acc_hit && req_write;

  assign ds_we    = (acc_hit && req_write) || fill_done;
  assign ds_wline = fill_done
                  ? (l_write ? put_word(mem_rline, l_wsel, l_wdata) : mem_rline)
                  : put_word(ds_line, wsel_of(req_vaddr), req_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= acc_fault || acc_hit || fill_done;
      resp_fault <= acc_fault;
      if (fill_done)     resp_rdata <= get_word(mem_rline, l_wsel);
      else if (acc_hit)  resp_rdata <= get_word(ds_line, wsel_of(req_vaddr));
      else if (acc_fault) resp_rdata <= '0;
    end
  end

  // R3
  hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> (resp_valid && !resp_fault && !mem_req));
  // R5
  fault_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |=> (resp_valid && resp_fault && !mem_req));
  // R8
  wb_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WBACK) |-> (mem_we && mem_addr[PA_W-1:OFF_W] == ts_pline));
  // R6
  fill_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) |-> (!mem_we && mem_addr[OFF_W-1:0] == '0));
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R12
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
endmodule

// File: rtl/virt_pid_cache.sv
module virt_pid_cache #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PID_W      = 8,
  parameter int LINES      = 256,
  parameter int LINE_BYTES = 32,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  output logic              resp_fault,
  output logic [31:0]       resp_rdata,
  output logic              xlt_valid,
  output logic [PID_W-1:0]  xlt_pid,
  output logic [VA_W-1:0]   xlt_vaddr,
  input  logic [PA_W-1:0]   xlt_paddr,
  input  logic              xlt_fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rline
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int VTAG_W = VA_W - IDX_W - OFF_W;
  localparam int PLN_W  = PA_W - OFF_W;

  logic [IDX_W-1:0]  ts_idx;
  logic              ts_valid, ts_dirty, ts_fill, ts_fill_dirty, ts_mark_dirty;
  logic [VTAG_W-1:0] ts_vtag, ts_new_vtag;
  logic [PID_W-1:0]  ts_pid, ts_new_pid;
  logic [PLN_W-1:0]  ts_pline, ts_new_pline;
  logic [LINE_W-1:0] ds_line, ds_wline;
  logic              ds_we;

  assign xlt_valid = req_valid && req_ready;
  assign xlt_pid   = req_pid;
  assign xlt_vaddr = req_vaddr;

  vpc_tag_store #(
    .LINES(LINES), .IDX_W(IDX_W), .VTAG_W(VTAG_W), .PID_W(PID_W), .PLN_W(PLN_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .idx(ts_idx),
    .rd_valid(ts_valid), .rd_dirty(ts_dirty), .rd_vtag(ts_vtag),
    .rd_pid(ts_pid), .rd_pline(ts_pline),
    .fill(ts_fill), .fill_dirty(ts_fill_dirty), .new_vtag(ts_new_vtag),
    .new_pid(ts_new_pid), .new_pline(ts_new_pline), .mark_dirty(ts_mark_dirty)
  );

  vpc_data_store #(
    .LINES(LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)
  ) u_data (
    .clk(clk), .idx(ts_idx), .rd_line(ds_line), .we(ds_we), .wr_line(ds_wline)
  );

  vpc_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .PID_W(PID_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_pid(req_pid), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_rdata(resp_rdata),
    .xlt_paddr(xlt_paddr), .xlt_fault(xlt_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wline(mem_wline), .mem_ack(mem_ack), .mem_rline(mem_rline),
    .ts_idx(ts_idx), .ts_valid(ts_valid), .ts_dirty(ts_dirty), .ts_vtag(ts_vtag),
    .ts_pid(ts_pid), .ts_pline(ts_pline), .ts_fill(ts_fill),
    .ts_fill_dirty(ts_fill_dirty), .ts_new_vtag(ts_new_vtag),
    .ts_new_pid(ts_new_pid), .ts_new_pline(ts_new_pline),
    .ts_mark_dirty(ts_mark_dirty),
    .ds_line(ds_line), .ds_we(ds_we), .ds_wline(ds_wline)
  );
endmodule

// File: tb/virt_pid_cache_test.sv
module virt_pid_cache_test;
  localparam int LW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_pid = '0;
  logic [31:0] req_vaddr = '0, req_wdata = '0;
  logic req_ready, resp_valid, resp_fault;
  logic [31:0] resp_rdata;
  logic xlt_valid;
  logic [7:0]  xlt_pid;
  logic [31:0] xlt_vaddr, xlt_paddr;
  logic xlt_fault;
  logic mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [LW-1:0] mem_wline;
  logic mem_ack = 1'b0;
  logic [LW-1:0] mem_rline = '0;
  logic [19:0] salt = '0;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic        fault;
    logic        chk_rd;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [LW-1:0] wl;
    string       tag;
  } mexp_t;

  exp_t  exp_q[$];
  mexp_t mem_q[$];
  logic [31:0] pmem [logic [29:0]];

  always #5 clk = ~clk;

  virt_pid_cache #(
    .VA_W(32), .PA_W(32), .PID_W(8), .LINES(4), .LINE_BYTES(8)
  ) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_pid(req_pid), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_rdata(resp_rdata),
    .xlt_valid(xlt_valid), .xlt_pid(xlt_pid), .xlt_vaddr(xlt_vaddr),
    .xlt_paddr(xlt_paddr), .xlt_fault(xlt_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wline(mem_wline), .mem_ack(mem_ack), .mem_rline(mem_rline)
  );

  // translation model: page = vpage + pid + salt, top nibble F faults
  assign xlt_fault = (xlt_vaddr[31:28] == 4'hF);
  assign xlt_paddr = {xlt_vaddr[31:12] + 20'(xlt_pid) + salt, xlt_vaddr[11:0]};

  function automatic logic [31:0] dflt(input logic [31:0] pa);
    return {pa[31:2], 2'b00} ^ 32'h5A00_00C3;
  endfunction
  function automatic logic [31:0] rdw(input logic [31:0] pa);
    return pmem.exists(pa[31:2]) ? pmem[pa[31:2]] : dflt(pa);
  endfunction

  task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic exp_mem(input logic we, input logic [31:0] a, input logic [LW-1:0] wl,
                         input string tag);
    mem_q.push_back('{we, a, wl, tag});
  endtask

  task automatic apply(input logic [7:0] pid, input logic [31:0] va, input logic wr,
                       input logic [31:0] wd, input logic efault, input logic chkrd,
                       input logic [31:0] erd, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_q.push_back('{efault, chkrd, erd, tag});
    req_valid = 1'b1; req_pid = pid; req_vaddr = va; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk({tag, " R12 single response pulse"}, LW'(resp_valid), LW'(0));
    chk({tag, " memory traffic as expected"}, LW'(mem_q.size()), LW'(0));
    mem_q.delete();
  endtask

  // response monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R12 unexpected response", LW'(1), LW'(0));
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " fault flag"}, LW'(resp_fault), LW'(e.fault));
        if (e.chk_rd) chk({e.tag, " read data"}, LW'(resp_rdata), LW'(e.rd));
      end
    end
  end

  // memory responder and memory scoreboard
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (rst_n && mem_req) begin
        logic [31:0] a;
        logic w;
        a = mem_addr;
        w = mem_we;
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          chk("R11 request held", {mem_req, mem_we, mem_addr}, {1'b1, w, a});
          chk("R12 busy not ready", LW'(req_ready), LW'(0));
        end
        if (mem_q.size() == 0) begin
          chk("unexpected memory transfer", {w, a}, '0);
        end else begin
          mexp_t m;
          m = mem_q.pop_front();
          chk({m.tag, " mem dir/addr"}, {w, a}, {m.we, m.addr});
          if (m.we) chk({m.tag, " write-back line"}, mem_wline, m.wl);
        end
        if (w) begin
          pmem[a[31:2]]      = mem_wline[31:0];
          pmem[a[31:2] + 1]  = mem_wline[63:32];
        end else begin
          mem_rline = {rdw(a + 4), rdw(a)};
        end
        mem_ack = 1'b1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", LW'(req_ready), LW'(1));
    chk("R1 resp_valid", LW'(resp_valid), LW'(0));
    chk("R1 mem_req", LW'(mem_req), LW'(0));

    // R1 / R6: first access misses, clean fill at translated address
    exp_mem(1'b0, 32'h0000_2000, '0, "R6 fill");
    apply(8'd1, 32'h0000_1004, 1'b0, '0, 1'b0, 1'b1, dflt(32'h2004), "R6 read miss");

    // R2: low bits ignored, word select
    apply(8'd1, 32'h0000_1007, 1'b0, '0, 1'b0, 1'b1, dflt(32'h2004), "R2 byte bits ignored");
    apply(8'd1, 32'h0000_1000, 1'b0, '0, 1'b0, 1'b1, dflt(32'h2000), "R2 word 0");

    // R3: hit ignores the translated address
    salt = 20'd5;
    apply(8'd1, 32'h0000_1004, 1'b0, '0, 1'b0, 1'b1, dflt(32'h2004), "R3 hit ignores paddr");
    salt = 20'd0;

    // R4: same VA, other process misses
    exp_mem(1'b0, 32'h0000_3000, '0, "R4 fill");
    apply(8'd2, 32'h0000_1000, 1'b0, '0, 1'b0, 1'b1, dflt(32'h3000), "R4 pid miss");
    exp_mem(1'b0, 32'h0000_2000, '0, "R4 refill");
    apply(8'd1, 32'h0000_1000, 1'b0, '0, 1'b0, 1'b1, dflt(32'h2000), "R4 back to pid1");
    exp_mem(1'b0, 32'h0000_3000, '0, "R4 fill again");
    apply(8'd2, 32'h0000_1000, 1'b0, '0, 1'b0, 1'b1, dflt(32'h3000), "R4 pid2 again");

    // R7: write hit
    apply(8'd2, 32'h0000_1004, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, '0, "R7 write hit");
    apply(8'd2, 32'h0000_1004, 1'b0, '0, 1'b0, 1'b1, 32'hDEAD_BEEF, "R7 read back");
    apply(8'd2, 32'h0000_1000, 1'b0, '0, 1'b0, 1'b1, dflt(32'h3000), "R7 other word kept");

    // R8: dirty eviction to stored physical address, then fill
    exp_mem(1'b1, 32'h0000_3000, {32'hDEAD_BEEF, dflt(32'h3000)}, "R8 write-back");
    exp_mem(1'b0, 32'h0000_2020, '0, "R8 fill after wb");
    apply(8'd1, 32'h0000_1020, 1'b0, '0, 1'b0, 1'b1, dflt(32'h2020), "R8 dirty evict");
    exp_mem(1'b0, 32'h0000_3000, '0, "R8 refetch");
    apply(8'd2, 32'h0000_1004, 1'b0, '0, 1'b0, 1'b1, 32'hDEAD_BEEF, "R8 data reached memory");

    // R5: fault aborts, dirty victim untouched
    apply(8'd2, 32'h0000_1000, 1'b1, 32'h1234_5678, 1'b0, 1'b0, '0, "R5 setup write");
    apply(8'd2, 32'hF000_1000, 1'b0, '0, 1'b1, 1'b0, '0, "R5 fault");
    apply(8'd2, 32'h0000_1000, 1'b0, '0, 1'b0, 1'b1, 32'h1234_5678, "R5 state unchanged");

    // R9: write miss allocates
    exp_mem(1'b0, 32'h0000_4008, '0, "R9 fill");
    apply(8'd3, 32'h0000_1008, 1'b1, 32'hCAFE_F00D, 1'b0, 1'b0, '0, "R9 write miss");
    apply(8'd3, 32'h0000_1008, 1'b0, '0, 1'b0, 1'b1, 32'hCAFE_F00D, "R9 merged word");
    apply(8'd3, 32'h0000_100C, 1'b0, '0, 1'b0, 1'b1, dflt(32'h400C), "R9 filled word");

    // R10: flush drops all lines, no write-back
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk("R10 ready low during flush", LW'(req_ready), LW'(0));
    @(negedge clk);
    flush = 1'b0;
    exp_mem(1'b0, 32'h0000_3000, '0, "R10 fill after flush");
    apply(8'd2, 32'h0000_1000, 1'b0, '0, 1'b0, 1'b1, dflt(32'h3000), "R10 dirty line dropped");
    exp_mem(1'b0, 32'h0000_4008, '0, "R10 fill idx1");
    apply(8'd3, 32'h0000_1008, 1'b0, '0, 1'b0, 1'b1, dflt(32'h4008), "R10 second line dropped");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule